// File: doc/BRIEF.md
# Four-Channel Prescaled Interval Timer

This block holds four independent 16-bit interval timers, reached through a small memory-mapped register port. Each channel has an up-counter, a compare register and an 8-bit control register. The control register carries two enables and a power-of-two prescaler select. The first enable gates the channel's clock path. The second lets the counter advance.

Every prescaled tick either increments the counter or, when the count equals the compare value, reloads it to zero. On a reload the channel emits a one-cycle interrupt pulse. Software sets the interrupt rate by choosing a prescaler ratio and a compare value. Counts are read-only from the bus. A read of any unmapped offset returns zero.

Top module: `ivt_top`

## Requirements
- R1: After reset every count, compare and control register reads 0 and all four interrupt outputs are low.
- R2: Channel n occupies byte addresses 0x10*n to 0x10*n+0xF. Within a channel, offset 0x0 is the count, 0x4 is the compare value and 0x8 is the control register. Any other offset reads 0.
- R3: In the control register, bit 0 is the clock enable, bit 1 is the count enable and bits 6:4 are the prescaler select. Bits 7, 3 and 2 read as 0 and are ignored on write, so writing 0xFF reads back 0x73.
- R4: The prescaler divides the system clock by 2^(select+2). Select 0 gives a ratio of 4 and select 7 gives a ratio of 512.
- R5: With both enables set, the counter advances once per prescaled tick. On the tick where the count equals the compare value it reloads to 0, so interrupt pulses repeat every (compare+1)*ratio system clocks.
- R6: Each interrupt pulse lasts exactly one system clock.
- R7: While the clock enable is 0, the prescaler and the counter are held at 0.
- R8: While the clock enable is 1 and the count enable is 0, the counter keeps its value.
- R9: Writes to the count offset are ignored.
- R10: Channels are independent. Each runs at its own rate, and the configuration of one has no effect on another.
- R11: A compare write takes effect at the channel's next compare check, including while the channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte address: channel in bits 5:4, register offset in bits 3:0 |
| busWrite | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data for busAddr |
| irq | output | 4 | One-cycle compare-match pulse per channel |

## Verification
The assertions assume that reset is applied before the first clock edge that matters. They also assume that every bus write completes within a single cycle, so the enables and the prescaler select are always register outputs and never glitch inside a cycle. The one-cycle pulse property further relies on a prescaler ratio of at least four, so two ticks can never fall on adjacent cycles. The bench only raises a compare value while its channel is running, never lowers it, so no counter has to wrap through the full 16-bit range. It keeps the random prescaler selects and compare values small, so each measured interrupt period fits well inside the wait limits.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int NUM_CH   = 4;
  localparam int CNT_W    = 16;
  localparam int SEL_W    = 3;
  localparam int MIN_LOG2 = 2;

  // Per-channel control strobes handed from the register block to a datapath
  typedef struct packed {
    logic             clear;  // clock path disabled: hold prescaler and counter at zero
    logic             run;    // clock path and counting both enabled
    logic [SEL_W-1:0] sel;    // prescaler select, ratio 2^(sel+MIN_LOG2)
  } chanStrobe_t;
endpackage

// File: rtl/ivt_chan.sv
module ivt_chan
  import ivt_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int SW  = SEL_W,
  parameter int ML2 = MIN_LOG2
) (
  input  logic          clk,
  input  logic          rstN,
  input  chanStrobe_t   strobe,
  input  logic [CW-1:0] cmpVal,
  output logic [CW-1:0] cntVal,
  output logic          irq
);
  localparam int PSC_W = ML2 + (1 << SW) - 1;
  localparam int SH_W  = $clog2(PSC_W + 1);

  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] pscLimit;
  logic [SH_W-1:0]  shAmt;
  logic             tick;
  logic             match;

  // Divide-by-2^(sel+ML2): the limit is the last prescaler state before a tick
  always_comb begin
    shAmt    = SH_W'(strobe.sel) + SH_W'(ML2);
    pscLimit = (PSC_W'(1) << shAmt) - PSC_W'(1);
    tick     = strobe.run && (psc >= pscLimit);
    match    = (cntVal == cmpVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psc    <= '0;
      cntVal <= '0;
      irq    <= 1'b0;
    end else if (strobe.clear) begin
      psc    <= '0;
      cntVal <= '0;
      irq    <= 1'b0;
    end else if (tick) begin
      psc <= '0;
      if (match) begin
        cntVal <= '0;
        irq    <= 1'b1;
      end else begin
        cntVal <= cntVal + CW'(1);
        irq    <= 1'b0;
      end
    end else begin
      if (strobe.run) psc <= psc + PSC_W'(1);
      irq <= 1'b0;
    end
  end

  // R6: a pulse never lasts more than one clock
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R5: a pulse coincides with the counter having reloaded to zero
  a_r5_reload_zero: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (cntVal == '0));

  // R7: clock path off forces prescaler and counter to zero
  a_r7_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (cntVal == '0 && psc == '0));

  // R8: clock on, count off keeps the counter frozen
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.run) |=> $stable(cntVal));
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int NC = NUM_CH,
  parameter int CW = CNT_W,
  parameter int SW = SEL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [$clog2(NC)+3:0]  busAddr,
  input  logic                   busWrite,
  input  logic [CW-1:0]          busWdata,
  input  logic [NC-1:0][CW-1:0]  cntVals,
  output chanStrobe_t [NC-1:0]   strobes,
  output logic [NC-1:0][CW-1:0]  cmpVals,
  output logic [CW-1:0]          busRdata
);
  localparam int IDX_W = $clog2(NC);
  localparam logic [3:0] OFF_CNT = 4'h0;
  localparam logic [3:0] OFF_CMP = 4'h4;
  localparam logic [3:0] OFF_CTL = 4'h8;

  logic [IDX_W-1:0] chanIdx;
  logic [3:0]       regOff;
  logic [NC-1:0][SW-1:0] selRegs;
  logic [NC-1:0]    ceRegs;
  logic [NC-1:0]    caeRegs;

  assign chanIdx = busAddr[IDX_W+3:4];
  assign regOff  = busAddr[3:0];

  for (genvar ch = 0; ch < NC; ch++) begin : g_regs
    logic hit;
    assign hit = busWrite && (chanIdx == IDX_W'(ch));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpVals[ch] <= '0;
        selRegs[ch] <= '0;
        ceRegs[ch]  <= 1'b0;
        caeRegs[ch] <= 1'b0;
      end else if (hit) begin
        if (regOff == OFF_CMP) cmpVals[ch] <= busWdata;
        if (regOff == OFF_CTL) begin
          selRegs[ch] <= busWdata[4 +: SW];
          ceRegs[ch]  <= busWdata[1];
          caeRegs[ch] <= busWdata[0];
        end
      end
    end

    assign strobes[ch].clear = !caeRegs[ch];
    assign strobes[ch].run   = caeRegs[ch] && ceRegs[ch];
    assign strobes[ch].sel   = selRegs[ch];
  end

  always_comb begin
    busRdata = '0;
    unique case (regOff)
      OFF_CNT: busRdata = cntVals[chanIdx];
      OFF_CMP: busRdata = cmpVals[chanIdx];
      OFF_CTL: begin
        busRdata[4 +: SW] = selRegs[chanIdx];
        busRdata[1]       = ceRegs[chanIdx];
        busRdata[0]       = caeRegs[chanIdx];
      end
      default: busRdata = '0;
    endcase
  end

  // R2: unmapped offsets read back zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regOff != OFF_CNT && regOff != OFF_CMP && regOff != OFF_CTL) |-> (busRdata == '0));

  // R3: a control read never shows the reserved bits
  a_r3_reserved_low: assert property (@(posedge clk) disable iff (!rstN)
    (regOff == OFF_CTL) |-> (busRdata[7] == 1'b0 && busRdata[3:2] == 2'b00));
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  busAddr,
  input  logic        busWrite,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic [3:0]  irq
);
  chanStrobe_t [NUM_CH-1:0]      strobes;
  logic [NUM_CH-1:0][CNT_W-1:0]  cmpVals;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntVals;

  ivt_regs #(.NC(NUM_CH), .CW(CNT_W), .SW(SEL_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .cntVals  (cntVals),
    .strobes  (strobes),
    .cmpVals  (cmpVals),
    .busRdata (busRdata)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ivt_chan #(.CW(CNT_W), .SW(SEL_W), .ML2(MIN_LOG2)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobes[ch]),
      .cmpVal (cmpVals[ch]),
      .cntVal (cntVals[ch]),
      .irq    (irq[ch])
    );
  end
endmodule

// File: tb/ivt_top_bench.sv
module ivt_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ivt_top u_ivt_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic int expPeriod(int cmp, int sel);
    return (cmp + 1) << (sel + 2);
  endfunction

  function automatic logic [15:0] ctlWord(int sel, bit ce, bit cae);
    return 16'((sel & 7) << 4) | 16'({ce, cae});
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int off, logic [15:0] data);
    @(negedge clk);
    busAddr  = 6'(ch * 16 + off);
    busWdata = data;
    busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(int ch, int off, output int val);
    busAddr = 6'(ch * 16 + off);
    #1;
    val = int'(busRdata);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Waits for a pulse on channel ch, then measures the gap to the next one
  task automatic measure(int ch, string req, output int period);
    int n = 0;
    period = -1;
    while (!irq[ch] && n < 20000) begin @(negedge clk); n++; end
    if (!irq[ch]) begin check(req, 0, 1); return; end
    @(negedge clk);
    check("R6", int'(irq[ch]), 0);
    n = 1;
    while (!irq[ch] && n < 20000) begin @(negedge clk); n++; end
    if (irq[ch]) period = n;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v, v2, p, p0, p3;
    int seedInit;
    seedInit = int'($urandom(32'h5eed));
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int ch = 0; ch < 4; ch++) begin
      for (int off = 0; off <= 8; off += 4) begin
        rd(ch, off, v);
        check("R1", v, 0);
      end
    end
    check("R1", int'(irq), 0);

    // R3: reserved control bits, R2: unmapped offset
    wr(2, 8, 16'h00FF);
    rd(2, 8, v);
    check("R3", v, 16'h73);
    wr(2, 8, 16'h0000);
    wr(1, 4, 16'hBEEF);
    rd(1, 4, v);
    check("R2", v, 16'hBEEF);
    rd(1, 12, v);
    check("R2", v, 0);
    rd(1, 2, v);
    check("R2", v, 0);
    rd(0, 4, v);
    check("R10", v, 0);
    wr(1, 4, 16'h0000);

    // R4/R5: smallest ratio with compare 0
    wr(0, 4, 16'd0);
    wr(0, 8, ctlWord(0, 1, 1));
    measure(0, "R5", p);
    check("R5", p, expPeriod(0, 0));
    wr(0, 8, 16'h0);

    // R4: largest ratio
    wr(0, 4, 16'd1);
    wr(0, 8, ctlWord(7, 1, 1));
    measure(0, "R4", p);
    check("R4", p, expPeriod(1, 7));
    wr(0, 8, 16'h0);

    // R11: raise compare while running
    wr(3, 4, 16'd3);
    wr(3, 8, ctlWord(1, 1, 1));
    measure(3, "R11", p);
    check("R11", p, expPeriod(3, 1));
    wr(3, 4, 16'd9);
    measure(3, "R11", p);
    check("R11", p, expPeriod(9, 1));
    wr(3, 8, 16'h0);

    // R8 hold, R9 read-only count, R7 clear
    wr(1, 4, 16'd1000);
    wr(1, 8, ctlWord(0, 1, 1));
    idle(100);
    wr(1, 8, ctlWord(0, 0, 1));
    rd(1, 0, v);
    check("R8", int'(v > 0), 1);
    idle(40);
    rd(1, 0, v2);
    check("R8", v2, v);
    wr(1, 0, 16'h1234);
    rd(1, 0, v2);
    check("R9", v2, v);
    wr(1, 8, ctlWord(0, 1, 0));
    idle(20);
    rd(1, 0, v2);
    check("R7", v2, 0);
    wr(1, 8, 16'h0);

    // R10: two channels at different rates together
    wr(0, 4, 16'd2);
    wr(3, 4, 16'd4);
    wr(0, 8, ctlWord(0, 1, 1));
    wr(3, 8, ctlWord(1, 1, 1));
    measure(0, "R10", p0);
    measure(3, "R10", p3);
    check("R10", p0, expPeriod(2, 0));
    check("R10", p3, expPeriod(4, 1));
    rd(2, 0, v);
    check("R10", v, 0);
    wr(0, 8, 16'h0);
    wr(3, 8, 16'h0);

    // R5: random channels, compares and ratios
    for (int it = 0; it < 8; it++) begin
      int ch, cmp, sel;
      ch  = int'($urandom % 4);
      cmp = int'($urandom % 20);
      sel = int'($urandom % 3);
      wr(ch, 4, 16'(cmp));
      wr(ch, 8, ctlWord(sel, 1, 1));
      measure(ch, "R5", p);
      check("R5", p, expPeriod(cmp, sel));
      wr(ch, 8, 16'h0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule